// File: doc/BRIEF.md
# Optical Black Clamp Engine

This block removes the sensor's black level from a raw Bayer pixel stream. Each incoming pixel carries its column, its row and a two-bit colour index. The block estimates the black level in two ways. The horizontal estimate averages one rectangular sample window of optical-black pixels. That window is either the first or the last of a row of equally sized windows. The vertical estimate is a running value that moves toward the average of a short optical-black span, once on each line inside an optical-black band.

The sum of the enabled estimates is subtracted from every pixel at or below a programmable start row. A signed DC offset is then added. The result is clipped to the 12-bit pixel range and leaves the block one cycle after it entered. A frame-start pulse clears the window accumulators and applies the vertical reset policy. Geometry, modes and offsets are plain configuration inputs that a register bank outside the block drives.

Top module: `ob_clamp`

## Requirements
- R1: The output is pix − clamp + dc_offset, saturated to 0..4095. dc_offset is a 13-bit two's-complement value and is added whether or not clamping is on. With clamp_en = 0 the clamp term is zero.
- R2: out_valid and out_data are registered. The result for a pixel accepted on one clock edge appears after that edge and holds until the next one.
- R3: In hmode 1, when color_sep = 0, the horizontal term is the mean of all pixels in the base window. This term is used from the second cycle after the window's last pixel.
- R4: With color_sep = 1, the horizontal term for pixel colour c (pix_col) is the mean of only the colour-c pixels in the base window. Each colour holds one quarter of the window's pixels.
- R5: In hmode 2, nothing is accumulated and the horizontal term keeps the value computed in an earlier frame.
- R6: In hmode 0, the horizontal term is not subtracted, but the window mean is still computed.
- R7: The window width is 2 << win_w_sel pixels and the height is 32 << win_h_sel lines. With base_right = 0 the base window starts at column win_x0. With base_right = 1 it starts at win_x0 + win_cnt_m1·width, where win_cnt_m1 + 1 is the number of windows (1..32).
- R8: With limit_en = 1, sample pixels above 1023 count as 1023 in both averages. The subtracted pixels themselves are never limited.
- R9: On frame_start the vertical value is loaded according to vreset_sel. 0 loads the shared horizontal mean, 1 loads vreset_val, and 2 or 3 keeps the previous value.
- R10: On rows ob_y0 .. ob_y0+ob_h−1, the pixels at columns ob_x0 .. ob_x0+(2 << ob_w_sel)−1 are averaged. At the last pixel of that span the vertical value v becomes v + floor((avg − v)·line_coef / 256).
- R11: Pixels with pix_y < sub_row get no clamp subtraction; only the DC offset is added.
- R12: After reset out_valid = 0, out_data = 0, and all clamp values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse before a frame's pixels |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_data | input | 12 | Raw pixel value |
| pix_x | input | 13 | Pixel column |
| pix_y | input | 13 | Pixel row |
| pix_col | input | 2 | Bayer colour index |
| clamp_en | input | 1 | Enable clamp subtraction |
| color_sep | input | 1 | 1: per-colour horizontal values, 0: shared |
| dc_offset | input | 13 | Signed offset always added |
| sub_row | input | 13 | First row that is clamped |
| hmode | input | 2 | Horizontal mode: 0 off, 1 compute, 2 hold |
| limit_en | input | 1 | Limit sample pixels to 1023 |
| base_right | input | 1 | Select the rightmost window as base |
| win_cnt_m1 | input | 5 | Number of windows minus one |
| win_x0 | input | 13 | Window row start column |
| win_y0 | input | 13 | Window start row |
| win_w_sel | input | 2 | Window width code |
| win_h_sel | input | 2 | Window height code |
| vreset_sel | input | 2 | Vertical reset policy |
| vreset_val | input | 12 | Configured vertical reset value |
| line_coef | input | 8 | Q8 line-average weight |
| ob_x0 | input | 13 | Vertical span start column |
| ob_y0 | input | 13 | Vertical band start row |
| ob_h | input | 13 | Vertical band height in lines |
| ob_w_sel | input | 2 | Vertical span width code |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | 12 | Clamped pixel |

## Verification
The bench builds the block with its default parameters: 12-bit pixels and 13-bit coordinates. It drives only the pixels that matter, at chosen coordinates, rather than full rasters. The smallest windows (2×32 and 4×32) and a 2×64 window keep every frame to a few hundred cycles. At that size, per-colour means, shared means, the rightmost-base offset and the limit path can all be reached. A two-pixel optical-black span with a half weight gives exact, hand-checkable steps of the running vertical value. A table of offset cases covers saturation at both ends of the range.

// File: rtl/ob_clamp.sv
module ob_clamp #(
  parameter int DW = 12,
  parameter int CW = 13,
  parameter int LIMV = 1023
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [1:0]    pix_col,
  input  logic          clamp_en,
  input  logic          color_sep,
  input  logic [CW-1:0] dc_offset,
  input  logic [CW-1:0] sub_row,
  input  logic [1:0]    hmode,
  input  logic          limit_en,
  input  logic          base_right,
  input  logic [4:0]    win_cnt_m1,
  input  logic [CW-1:0] win_x0,
  input  logic [CW-1:0] win_y0,
  input  logic [1:0]    win_w_sel,
  input  logic [1:0]    win_h_sel,
  input  logic [1:0]    vreset_sel,
  input  logic [DW-1:0] vreset_val,
  input  logic [7:0]    line_coef,
  input  logic [CW-1:0] ob_x0,
  input  logic [CW-1:0] ob_y0,
  input  logic [CW-1:0] ob_h,
  input  logic [1:0]    ob_w_sel,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int XW   = CW + 6;
  localparam int ACW  = DW + 12;
  localparam int LW   = DW + 5;
  localparam int PW   = DW + 10;
  localparam int SW   = DW + 3;
  localparam logic [DW-1:0] MAXV = {DW{1'b1}};

  logic [ACW-1:0] acc [4];
  logic [DW-1:0]  hc [4];
  logic [DW-1:0]  hall, vcl;
  logic [LW-1:0]  lsum;
  logic           hdone, hlatch;

  wire [XW-1:0] px = XW'(pix_x);
  wire [XW-1:0] py = XW'(pix_y);

  wire [DW-1:0] lim = (limit_en && pix_data > DW'(LIMV)) ? DW'(LIMV) : pix_data;

  // horizontal sample window
  wire [2:0]    wlog = {1'b0, win_w_sel} + 3'd1;
  wire [3:0]    hshift = {1'b0, wlog} + {2'b0, win_h_sel} + 4'd5;
  wire [XW-1:0] wsz = XW'(2) << win_w_sel;
  wire [XW-1:0] hsz = XW'(32) << win_h_sel;
  wire [XW-1:0] bx  = XW'(win_x0) + (base_right ? (XW'(win_cnt_m1) << wlog) : '0);
  wire [XW-1:0] by  = XW'(win_y0);
  wire in_win = pix_valid && hmode != 2'd2 && !hdone &&
                px >= bx && px < bx + wsz && py >= by && py < by + hsz;
  wire win_last = in_win && px == bx + wsz - 1 && py == by + hsz - 1;
  wire [ACW+1:0] tot = ACW'(0) + acc[0] + acc[1] + acc[2] + acc[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        acc[c] <= '0;
        hc[c]  <= '0;
      end
      hall   <= '0;
      hdone  <= 1'b0;
      hlatch <= 1'b0;
    end else if (frame_start) begin
      for (int c = 0; c < 4; c++) acc[c] <= '0;
      hdone  <= 1'b0;
      hlatch <= 1'b0;
    end else begin
      if (in_win) acc[pix_col] <= acc[pix_col] + ACW'(lim);
      if (win_last) hdone <= 1'b1;
      hlatch <= win_last;
      if (hlatch && hmode != 2'd2) begin
        for (int c = 0; c < 4; c++) hc[c] <= DW'(acc[c] >> (hshift - 4'd2));
        hall <= DW'(tot >> hshift);
      end
    end
  end

  // vertical running value
  wire [XW-1:0] osz = XW'(2) << ob_w_sel;
  wire [2:0]    olog = {1'b0, ob_w_sel} + 3'd1;
  wire in_ob = pix_valid && py >= XW'(ob_y0) && py < XW'(ob_y0) + XW'(ob_h) &&
               px >= XW'(ob_x0) && px < XW'(ob_x0) + osz;
  wire ob_last = in_ob && px == XW'(ob_x0) + osz - 1;
  wire [LW-1:0] lsum_n = lsum + LW'(lim);
  wire [DW-1:0] avg = DW'(lsum_n >> olog);
  wire signed [DW:0]   delta = $signed({1'b0, avg}) - $signed({1'b0, vcl});
  wire signed [PW-1:0] prod  = PW'(delta) * PW'($signed({1'b0, line_coef}));
  wire signed [PW-1:0] vsum  = PW'($signed({1'b0, vcl})) + (prod >>> 8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcl  <= '0;
      lsum <= '0;
    end else if (frame_start) begin
      lsum <= '0;
      case (vreset_sel)
        2'd0:    vcl <= hall;
        2'd1:    vcl <= vreset_val;
        default: vcl <= vcl;
      endcase
    end else if (in_ob) begin
      if (ob_last) begin
        lsum <= '0;
        vcl  <= DW'(vsum);
      end else begin
        lsum <= lsum_n;
      end
    end
  end

  // subtraction, offset, saturation
  wire [DW-1:0] hterm = (hmode == 2'd0) ? '0 : (color_sep ? hc[pix_col] : hall);
  wire [DW:0]   clamp = (clamp_en && py >= XW'(sub_row)) ? ({1'b0, hterm} + {1'b0, vcl}) : '0;
  wire signed [SW-1:0] sres = $signed({3'b0, pix_data}) - $signed({2'b0, clamp})
                              + SW'($signed(dc_offset));
  wire [DW-1:0] sat = sres < 0 ? '0 : (sres > $signed({3'b0, MAXV}) ? MAXV : DW'(sres));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_data <= sat;
    end
  end

  // R2
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !clamp_en && dc_offset == '0) |=> out_data == $past(pix_data));
  // R11
  above_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && py < XW'(sub_row) && dc_offset == '0) |=> out_data == $past(pix_data));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hmode == 2'd2) |=> $stable(hall));
  // R10
  vert_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_last && !frame_start) |=>
      ((vcl <= $past(vcl) || vcl <= $past(avg)) && (vcl >= $past(vcl) || vcl >= $past(avg))));
endmodule

// File: tb/ob_clamp_tb_top.sv
`timescale 1ns/1ps
module ob_clamp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, pix_valid = 0;
  logic [11:0] pix_data = 0;
  logic [12:0] pix_x = 0, pix_y = 0;
  logic [1:0]  pix_col = 0;
  logic clamp_en = 0, color_sep = 0, limit_en = 0, base_right = 0;
  logic [12:0] dc_offset = 0, sub_row = 0, win_x0 = 0, win_y0 = 0;
  logic [1:0]  hmode = 0, win_w_sel = 0, win_h_sel = 0, vreset_sel = 1, ob_w_sel = 0;
  logic [4:0]  win_cnt_m1 = 0;
  logic [11:0] vreset_val = 0;
  logic [7:0]  line_coef = 0;
  logic [12:0] ob_x0 = 0, ob_y0 = 13'd8000, ob_h = 0;
  logic        out_valid;
  logic [11:0] out_data;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  ob_clamp dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_x(pix_x), .pix_y(pix_y), .pix_col(pix_col),
    .clamp_en(clamp_en), .color_sep(color_sep), .dc_offset(dc_offset), .sub_row(sub_row),
    .hmode(hmode), .limit_en(limit_en), .base_right(base_right), .win_cnt_m1(win_cnt_m1),
    .win_x0(win_x0), .win_y0(win_y0), .win_w_sel(win_w_sel), .win_h_sel(win_h_sel),
    .vreset_sel(vreset_sel), .vreset_val(vreset_val), .line_coef(line_coef),
    .ob_x0(ob_x0), .ob_y0(ob_y0), .ob_h(ob_h), .ob_w_sel(ob_w_sel),
    .out_valid(out_valid), .out_data(out_data));

  // pix, dc_offset, expected
  localparam logic [36:0] VEC [0:4] = '{
    {12'd100,  13'd5,     12'd105},
    {12'd100,  13'h1F38,  12'd0},
    {12'd4000, 13'd200,   12'd4095},
    {12'd0,    13'd0,     12'd0},
    {12'd4095, 13'h1FFF,  12'd4094}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic probe(input int x, input int y, input int c, input int v,
                       input int exp, input string tag);
    @(negedge clk);
    pix_valid = 1; pix_x = 13'(x); pix_y = 13'(y); pix_col = 2'(c); pix_data = 12'(v);
    @(negedge clk);
    pix_valid = 0;
    check({tag, " valid"}, int'(out_valid), 1);
    check(tag, int'(out_data), exp);
  endtask

  task automatic feed(input int x0, input int w, input int y0, input int h,
                      input int v0, input int v1, input int v2, input int v3);
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) begin
        @(negedge clk);
        pix_valid = 1; pix_x = 13'(x); pix_y = 13'(y);
        pix_col = {1'(y), 1'(x)};
        case ({1'(y), 1'(x)})
          2'd0: pix_data = 12'(v0);
          2'd1: pix_data = 12'(v1);
          2'd2: pix_data = 12'(v2);
          default: pix_data = 12'(v3);
        endcase
      end
    @(negedge clk);
    pix_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic fstart();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 out_valid", int'(out_valid), 0);
    check("R12 out_data", int'(out_data), 0);
    clamp_en = 1; hmode = 1;
    probe(5, 5, 0, 300, 300, "R12 zero clamps");
    clamp_en = 0;

    // R1 offset and saturation table
    for (int i = 0; i < 5; i++) begin
      dc_offset = VEC[i][24:12];
      probe(3, 3, 0, int'(VEC[i][36:25]), int'(VEC[i][11:0]), "R1 offset");
    end
    dc_offset = 0;

    // R3 R4 shared and per-colour means, R2 timing via probe
    clamp_en = 1; hmode = 1; vreset_sel = 1; vreset_val = 0;
    win_x0 = 10; win_y0 = 0; win_w_sel = 0; win_h_sel = 0;
    fstart();
    feed(10, 2, 0, 32, 40, 80, 120, 160);
    probe(20, 40, 0, 500, 400, "R3 shared mean");
    color_sep = 1;
    probe(20, 40, 0, 500, 460, "R4 colour0");
    probe(21, 40, 1, 500, 420, "R4 colour1");
    probe(20, 41, 2, 500, 380, "R4 colour2");
    probe(21, 41, 3, 500, 340, "R4 colour3");
    color_sep = 0;

    // R5 hold previous frame value
    hmode = 2;
    fstart();
    feed(10, 2, 0, 32, 90, 90, 90, 90);
    probe(20, 40, 0, 500, 400, "R5 hold");

    // R6 mode 0: not subtracted, still computed (mean 90)
    hmode = 0;
    fstart();
    feed(10, 2, 0, 32, 90, 90, 90, 90);
    probe(20, 40, 0, 500, 500, "R6 no h term");

    // R9 vertical reset from shared horizontal mean
    vreset_sel = 0;
    fstart();
    probe(20, 40, 0, 500, 410, "R9 reset from h");

    // R10 running vertical value
    vreset_sel = 1; vreset_val = 100; line_coef = 128;
    ob_x0 = 0; ob_y0 = 100; ob_h = 2; ob_w_sel = 0;
    fstart();
    probe(20, 50, 0, 300, 200, "R9 reset configured");
    feed(0, 2, 100, 1, 200, 200, 200, 200);
    probe(20, 101, 0, 300, 150, "R10 first line");
    feed(0, 2, 101, 1, 200, 200, 200, 200);
    probe(20, 102, 0, 300, 125, "R10 second line");

    // R9 hold previous vertical value
    vreset_sel = 2; ob_y0 = 13'd8000;
    fstart();
    probe(20, 40, 0, 300, 125, "R9 hold");

    // R8 limit
    vreset_sel = 1; vreset_val = 0; hmode = 1; limit_en = 1;
    fstart();
    feed(10, 2, 0, 32, 2000, 2000, 2000, 2000);
    probe(20, 40, 0, 3000, 1977, "R8 limited");
    limit_en = 0;
    fstart();
    feed(10, 2, 0, 32, 2000, 2000, 2000, 2000);
    probe(20, 40, 0, 3000, 1000, "R8 unlimited");

    // R7 rightmost base window, width code 1
    win_x0 = 0; win_w_sel = 1; win_cnt_m1 = 3; base_right = 1;
    fstart();
    feed(0, 4, 0, 32, 10, 10, 10, 10);
    feed(12, 4, 0, 32, 70, 70, 70, 70);
    probe(40, 40, 0, 500, 430, "R7 base right");
    base_right = 0;
    fstart();
    feed(0, 4, 0, 32, 10, 10, 10, 10);
    feed(12, 4, 0, 32, 70, 70, 70, 70);
    probe(40, 40, 0, 500, 490, "R7 base left");

    // R7 height code 1
    win_x0 = 10; win_w_sel = 0; win_h_sel = 1; win_cnt_m1 = 0;
    fstart();
    feed(10, 2, 0, 64, 30, 30, 30, 30);
    probe(20, 70, 0, 500, 470, "R7 height 64");

    // R11 start row
    sub_row = 50;
    probe(20, 40, 0, 500, 500, "R11 above start row");
    probe(20, 60, 0, 500, 470, "R11 at start row");
    dc_offset = 13'h1FEC;
    probe(20, 60, 0, 500, 450, "R1 offset with clamp");
    dc_offset = 0;
    probe(20, 60, 0, 10, 0, "R1 low saturation");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule